// File: doc/BRIEF.md
# Hilbert FIR Envelope Detector

This block turns a stream of signed RF echo samples into an unsigned envelope stream. Every accepted sample enters a 33-position window. The quadrature component comes from a fixed Hilbert-transform FIR filter of order 32 applied to that window. The in-phase component is the window's centre sample, which is the filter's group delay of 16 samples. The envelope is the integer square root of I² + Q², and it saturates at the top of the output range.

The filter relies on two properties of its coefficients. They are odd-symmetric about the centre, and every even offset is zero. Each mirrored pair of window samples is therefore subtracted before it reaches a multiplier, and no hardware exists for the zero taps. Only 8 multipliers are built, where a direct-form filter needs 33.

The block takes one sample per clock and returns one result per clock. Its latency is fixed at 19 cycles, and a valid strobe travels alongside the data.

Top module: `env_detector`

## Requirements
- R1: The window holds the 33 most recently accepted samples, with index 0 the newest. After reset every position is zero. Idle cycles do not age the window, whatever their length.
- R2: Q = (S + 16384) >>> 15, an arithmetic shift. S is the sum over j = 0..7 of c[j]·(w[16+m] − w[16−m]), where m = 2j+1 and w is the window. The coefficients are c = 20861, 6954, 4172, 2980, 2318, 1896, 1605, 1391, which is round(2/(π·m)·32768).
- R3: I equals the centre sample w[16]. A constant input therefore gives Q = 0 and an envelope of |input|.
- R4: The envelope equals floor(sqrt(I² + Q²)), computed without loss of precision.
- R5: A sample presented with in_valid high in cycle t produces its envelope on env_out in cycle t+19.
- R6: out_valid equals in_valid delayed by 19 cycles. It is low for the first 19 cycles after reset.
- R7: A sample presented while in_valid is low never enters the window.
- R8: When I² + Q² exceeds 2^32 − 1, env_out is 65535. Full-scale inputs never wrap the output.
- R9: While reset is high, out_valid and env_out are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_sample as a sample to accept |
| in_sample | input | 16 | Signed RF sample, two's complement |
| out_valid | output | 1 | Marks env_out as a valid envelope |
| env_out | output | 16 | Unsigned envelope magnitude |

## Verification
The hardest condition to reach is saturation. It needs the largest possible quadrature value, which only occurs when the older half of the window sits at the positive rail and the newer half at the negative rail (or the reverse). The stimulus builds this pattern directly: 17 samples at one extreme followed by 16 at the other. A second hard condition is a window that keeps stale samples across long idle gaps. Bursts separated by gaps longer than the window reach it, and random valid strobes with garbage data on the idle cycles show that the window never moves when in_valid is low.

// File: rtl/env_det_pkg.sv
package env_det_pkg;

    localparam int DATA_W     = 16;
    localparam int COEF_W     = 16;
    localparam int FILT_ORDER = 32;
    localparam int OUT_W      = 16;
    localparam int LATENCY    = 19;
    localparam int SQRT_BPS   = 2;

    localparam int TAPS     = FILT_ORDER + 1;
    localparam int CTR      = FILT_ORDER / 2;
    localparam int NPAIR    = (CTR + 1) / 2;
    localparam int DIFF_W   = DATA_W + 1;
    localparam int PROD_W   = DIFF_W + COEF_W;
    localparam int TREE_LVL = $clog2(NPAIR);
    localparam int ACC_W    = PROD_W + TREE_LVL;
    localparam int FRAC     = COEF_W - 1;
    localparam int Q_W      = ACC_W + 1 - FRAC;
    localparam int SQ_W     = 2 * Q_W + 1;
    localparam int RAD_W    = 2 * OUT_W;
    localparam int REM_W    = OUT_W + 3;
    localparam int NSTG     = OUT_W / SQRT_BPS;
    localparam int CORE     = 3 + TREE_LVL + 1 + NSTG;
    localparam int PAD      = LATENCY - CORE;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [DIFF_W-1:0] diff_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [OUT_W-1:0]         env_t;

    // Nonzero Hilbert taps at odd offsets 2j+1 from the centre, Q1.15
    function automatic coef_t hilb_coef(input int j);
        case (j)
            0:       return coef_t'(20861);
            1:       return coef_t'(6954);
            2:       return coef_t'(4172);
            3:       return coef_t'(2980);
            4:       return coef_t'(2318);
            5:       return coef_t'(1896);
            6:       return coef_t'(1605);
            7:       return coef_t'(1391);
            default: return coef_t'(0);
        endcase
    endfunction

    function automatic longint coef_mag_sum();
        longint s = 0;
        for (int j = 0; j < NPAIR; j++) s += longint'(hilb_coef(j));
        return s;
    endfunction

    localparam longint QSUM_MAX = coef_mag_sum() * ((longint'(1) << DATA_W) - 1);

endpackage

// File: rtl/env_tap_line.sv
module env_tap_line
    import env_det_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  sample_t                 in_sample,
    output diff_t [NPAIR-1:0]       diff_o,
    output sample_t                 ctr_o
);

    typedef struct packed {
        sample_t [TAPS-1:0]  taps;
        diff_t   [NPAIR-1:0] diff;
        sample_t             ctr;
    } tap_st_t;

    tap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            for (int k = TAPS - 1; k > 0; k--) st_d.taps[k] = st_q.taps[k-1];
            st_d.taps[0] = in_sample;
        end
        // mirrored pair pre-subtraction: older minus newer
        for (int j = 0; j < NPAIR; j++) begin
            st_d.diff[j] = DIFF_W'($signed(st_q.taps[CTR+2*j+1]))
                         - DIFF_W'($signed(st_q.taps[CTR-2*j-1]));
        end
        st_d.ctr = st_q.taps[CTR];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign diff_o = st_q.diff;
    assign ctr_o  = st_q.ctr;

    AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (st_q.taps[0] == $past(in_sample)));             // R1
    AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(st_q.taps));                           // R7

endmodule

// File: rtl/env_hilbert_mac.sv
module env_hilbert_mac
    import env_det_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  diff_t [NPAIR-1:0]    diff_i,
    input  sample_t              ctr_i,
    output acc_t                 q_o,
    output sample_t              i_o
);

    typedef struct packed {
        prod_t   [NPAIR-1:0]                 prod;
        acc_t    [TREE_LVL-1:0][NPAIR-1:0]   acc;
        sample_t [TREE_LVL:0]                ipipe;
    } mac_st_t;

    mac_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int j = 0; j < NPAIR; j++) begin
            st_d.prod[j] = $signed(diff_i[j]) * $signed(hilb_coef(j));
        end
        for (int l = 0; l < TREE_LVL; l++) begin
            for (int k = 0; k < NPAIR; k++) begin
                if (k < (NPAIR >> (l + 1))) begin
                    if (l == 0) begin
                        st_d.acc[l][k] = ACC_W'($signed(st_q.prod[2*k]))
                                       + ACC_W'($signed(st_q.prod[2*k+1]));
                    end else begin
                        st_d.acc[l][k] = $signed(st_q.acc[l-1][2*k])
                                       + $signed(st_q.acc[l-1][2*k+1]);
                    end
                end else begin
                    st_d.acc[l][k] = '0;
                end
            end
        end
        st_d.ipipe[0] = ctr_i;
        for (int k = 1; k <= TREE_LVL; k++) st_d.ipipe[k] = st_q.ipipe[k-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q_o = st_q.acc[TREE_LVL-1][0];
    assign i_o = st_q.ipipe[TREE_LVL];

    AST_QSUM_RANGE: assert property (@(posedge clk) disable iff (rst)
        (longint'(q_o) <= QSUM_MAX) && (longint'(q_o) >= -QSUM_MAX));   // R2

endmodule

// File: rtl/env_mag_sqrt.sv
module env_mag_sqrt
    import env_det_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  acc_t     q_i,
    input  sample_t  i_i,
    output env_t     mag_o
);

    localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) << (FRAC - 1);

    typedef struct packed {
        logic [RAD_W-1:0]             rad_in;
        logic [NSTG-1:0][RAD_W-1:0]   rad;
        logic [NSTG-1:0][REM_W-1:0]   rem;
        env_t [NSTG-1:0]              root;
    } sq_st_t;

    sq_st_t st_d, st_q;

    logic signed [ACC_W:0]      rnd;
    logic signed [Q_W-1:0]      q_s;
    logic signed [2*Q_W-1:0]    q_sq;
    logic signed [2*DATA_W-1:0] i_sq;
    logic [SQ_W-1:0]            pwr;

    always_comb begin
        rnd  = (ACC_W+1)'(q_i) + HALF;
        q_s  = Q_W'(rnd >>> FRAC);
        q_sq = q_s * q_s;
        i_sq = i_i * i_i;
        pwr  = SQ_W'($unsigned(q_sq)) + SQ_W'($unsigned(i_sq));
    end

    always_comb begin
        logic [RAD_W-1:0] w_rad;
        logic [REM_W-1:0] w_rem;
        logic [REM_W-1:0] w_try;
        logic [REM_W-1:0] w_trial;
        env_t             w_root;
        st_d = st_q;
        st_d.rad_in = (|pwr[SQ_W-1:RAD_W]) ? '1 : pwr[RAD_W-1:0];
        for (int s = 0; s < NSTG; s++) begin
            if (s == 0) begin
                w_rad  = st_q.rad_in;
                w_rem  = '0;
                w_root = '0;
            end else begin
                w_rad  = st_q.rad[s-1];
                w_rem  = st_q.rem[s-1];
                w_root = st_q.root[s-1];
            end
            for (int b = 0; b < SQRT_BPS; b++) begin
                w_try   = {w_rem[REM_W-3:0], w_rad[RAD_W-1 -: 2]};
                w_trial = REM_W'({w_root, 2'b01});
                w_rad   = w_rad << 2;
                if (w_try >= w_trial) begin
                    w_rem  = w_try - w_trial;
                    w_root = {w_root[OUT_W-2:0], 1'b1};
                end else begin
                    w_rem  = w_try;
                    w_root = {w_root[OUT_W-2:0], 1'b0};
                end
            end
            st_d.rad[s]  = w_rad;
            st_d.rem[s]  = w_rem;
            st_d.root[s] = w_root;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mag_o = st_q.root[NSTG-1];

    for (genvar g = 0; g < NSTG; g++) begin : g_rem_chk
        AST_SQRT_REM: assert property (@(posedge clk) disable iff (rst)
            st_q.rem[g] <= REM_W'({st_q.root[g], 1'b0}));               // R4
    end

endmodule

// File: rtl/env_detector.sv
module env_detector
    import env_det_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         env_out
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    diff_t [NPAIR-1:0] diff_w;
    sample_t           ctr_w;
    acc_t              q_w;
    sample_t           i_w;
    env_t              mag_w;

    env_tap_line u_taps (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .diff_o    (diff_w),
        .ctr_o     (ctr_w)
    );

    env_hilbert_mac u_mac (
        .clk    (clk),
        .rst    (rst),
        .diff_i (diff_w),
        .ctr_i  (ctr_w),
        .q_o    (q_w),
        .i_o    (i_w)
    );

    env_mag_sqrt u_mag (
        .clk   (clk),
        .rst   (rst),
        .q_i   (q_w),
        .i_i   (i_w),
        .mag_o (mag_w)
    );

    typedef struct packed {
        logic [LATENCY-1:0]  vpipe;
        env_t [PAD-1:0]      epipe;
        logic [CNT_W-1:0]    since_rst;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.vpipe = {st_q.vpipe[LATENCY-2:0], in_valid};
        st_d.epipe[0] = mag_w;
        for (int k = 1; k < PAD; k++) st_d.epipe[k] = st_q.epipe[k-1];
        if (st_q.since_rst != CNT_W'(LATENCY)) st_d.since_rst = st_q.since_rst + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vpipe[LATENCY-1];
    assign env_out   = st_q.epipe[PAD-1];

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
        (st_q.since_rst < CNT_W'(LATENCY)) |-> !out_valid);          // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && env_out == '0));                       // R9

endmodule

// File: tb/env_detector_tb_top.sv
module env_detector_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic signed [15:0] in_sample;
    logic        out_valid;
    logic [15:0] env_out;

    env_detector dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .env_out   (env_out)
    );

    always #4 clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    int     cyc    = 0;
    bit     exp_v [32];
    longint exp_e [32];
    string  exp_t [32];
    int     win   [33];
    string  tag   = "R5";
    int     cf    [8] = '{20861, 6954, 4172, 2980, 2318, 1896, 1605, 1391};

    task automatic check(input string rq, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", rq, act, expv, cyc);
        end
    endtask

    function automatic longint model_env();
        longint q = 0;
        longint qs, i, s, r;
        for (int j = 0; j < 8; j++) q += longint'(cf[j]) * (win[17+2*j] - win[15-2*j]);
        qs = (q + 16384) >>> 15;
        i  = win[16];
        s  = i * i + qs * qs;
        if (s > 64'd4294967295) s = 64'd4294967295;
        r = longint'($rtoi($sqrt(real'(s))));
        while (r * r > s) r--;
        while ((r + 1) * (r + 1) <= s) r++;
        return r;
    endfunction

    task automatic step(input bit v, input int x);
        @(negedge clk);
        if (exp_v[cyc % 32]) begin
            check("R6", longint'(out_valid), 1);
            check(exp_t[cyc % 32], longint'(env_out), exp_e[cyc % 32]);
        end else begin
            check("R6", longint'(out_valid), 0);
        end
        in_valid  = v;
        in_sample = 16'(x);
        if (v) begin
            for (int k = 32; k > 0; k--) win[k] = win[k-1];
            win[0] = x;
            exp_e[(cyc + 19) % 32] = model_env();
        end
        exp_v[(cyc + 19) % 32] = v;
        exp_t[(cyc + 19) % 32] = tag;
        cyc++;
    endtask

    function automatic int rnd_sample();
        return int'($signed(16'($urandom())));
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 33; k++) win[k] = 0;
        for (int k = 0; k < 32; k++) begin
            exp_v[k] = 1'b0;
            exp_e[k] = 0;
            exp_t[k] = "R6";
        end
        rst = 1'b1;
        in_valid = 1'b0;
        in_sample = 16'sd1000;
        repeat (4) @(negedge clk);
        check("R9", longint'(out_valid), 0);   // R9 reset state
        check("R9", longint'(env_out), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        cyc = 1;

        // R5: single sample after silence, appears 19 cycles later
        tag = "R5";
        repeat (5) step(1'b0, 0);
        step(1'b1, 12000);
        repeat (30) step(1'b0, 0);

        // R2: impulse exposes every coefficient as it crosses the window
        tag = "R2";
        step(1'b1, 16384);
        repeat (40) step(1'b1, 0);
        step(1'b1, -9000);
        repeat (40) step(1'b1, 0);

        // R3: constant input gives Q of zero and envelope of |x|
        tag = "R3";
        repeat (40) step(1'b1, -20000);
        repeat (40) step(1'b1, 32767);

        // R8: extreme halves, largest |Q|, both polarities
        tag = "R8";
        repeat (17) step(1'b1, 32767);
        repeat (16) step(1'b1, -32768);
        step(1'b1, -32768);
        repeat (17) step(1'b1, -32768);
        repeat (16) step(1'b1, 32767);
        step(1'b1, 32767);

        // R1: bursts with gaps longer than the window keep stale samples
        tag = "R1";
        for (int b = 0; b < 4; b++) begin
            repeat (10) step(1'b1, rnd_sample());
            repeat (45) step(1'b0, 0);
        end

        // R7: random strobes, garbage on idle cycles
        tag = "R7";
        for (int k = 0; k < 400; k++) begin
            bit v = 1'($urandom());
            step(v, rnd_sample());
        end

        // R4: continuous full-range random data, then small amplitude
        tag = "R4";
        for (int k = 0; k < 400; k++) step(1'b1, rnd_sample());
        for (int k = 0; k < 200; k++) step(1'b1, rnd_sample() >>> 8);

        tag = "R6";
        repeat (25) step(1'b0, 0);
        finish_run();
    end

endmodule